// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog that host software programs through a small register file on a 32-bit I/O-style bus. Byte enables select the lanes of each access. A down-counter loads from a programmable timeout value and steps once per external tick-enable. Software restarts the count with a reload write and can freeze it with a halt bit. When the count runs out, a first-timeout status bit is set and the counter reloads and keeps going.

If software does not clear that status before the counter runs out again, the block escalates. It sets a second-timeout status bit and pulses a system-action output, unless the no-reboot input is high. Two message bytes let software raise software-interrupt status bits. A sticky lock bit, once written, stays set until reset.

Register map. The address is a dword index, and the byte lanes of each dword are listed low to high:

| Index | Lanes 0–1 | Lane 2 | Lane 3 |
|---|---|---|---|
| 0 | reload strobe on write; live counter on read, bits 9:0 | data-in message byte | data-out message byte |
| 1 | primary status: bit 1 message-in, bit 2 message-out, bit 3 timeout | secondary status, bits 17 and 18 (second-timeout and boot) | — |
| 2 | primary control: bit 11 halt, bit 12 lock | secondary control, bits 31:16 | — |
| 3 | lane 0 and lane 1: message bytes | watchdog-count byte | interrupt-generation byte |
| 4 | timeout value, bits 9:0 | — | — |

Top module: `wdt_top`

## Requirements
- R1: After reset, the dwords read as follows: index 0 reads 0x00000000, index 1 reads 0x00000000, index 2 reads 0x00080000, index 3 reads 0x03000000 and index 4 reads 0x00000004.
- R2: A write to index 0 with lane 0 or lane 1 enabled copies the timeout value into the counter. Bits 9:0 of an index 0 read return the live counter.
- R3: While the halt bit (bit 11 of index 2) is 1, ticks leave the counter unchanged. After the bit is written back to 0, counting resumes.
- R4: Each tick taken while not halted lowers the counter by exactly one, as long as the counter is above 1.
- R5: A tick that finds the counter at 1 (or 0) is an expiry. An expiry sets the timeout status (bit 3 of index 1) and reloads the counter from the timeout value. Loading N therefore gives expiry on exactly the Nth tick, and the counter reads 1 with status still clear after N-1 ticks.
- R6: Status bits are write-one-to-clear: writing 1 clears a bit and writing 0 leaves it unchanged. Writing back the value just read from index 1 leaves index 1 reading zero.
- R7: An expiry while the timeout status is still set sets the second-timeout status (bit 17 of index 1). An expiry with the timeout status clear does not set it.
- R8: The system-action output pulses high for one cycle on an expiry that occurs while the timeout status is set, but only when no_reboot_i is low. At no other time is it high.
- R9: Once the lock bit (bit 12 of index 2) is written as 1, later writes of 0 leave it at 1 until reset.
- R10: Writing the data-in byte (index 0, lane 2) sets status bit 1. Writing the data-out byte (index 0, lane 3) sets status bit 2.
- R11: Only enabled byte lanes are written. A write to lanes 2–3 of index 0 does not reload the counter. A write to lanes 2–3 of index 2 changes the secondary control but not halt or lock.
- R12: The timeout value is 10 bits wide and higher written bits are dropped, so a write of 0xFFFF holds 0x3FF and a write of 0x0403 holds 0x003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counter step enable, one per watchdog tick |
| no_reboot_i | input | 1 | High suppresses the system action |
| bus_addr_i | input | 3 | Dword index |
| bus_wr_i | input | 1 | Write strobe |
| bus_be_i | input | 4 | Byte-lane enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed dword, combinational |
| sys_action_o | output | 1 | One-cycle pulse on a second consecutive timeout |

## Verification
A wrong counter value shows on an index 0 read one cycle after the tick that produced it. An off-by-one in the expiry compare shows as the timeout status appearing one tick early or late. A status register that misses its set or its clear reveals itself one expiry later: the second-timeout bit and the action pulse appear when they should not, or stay absent when they should appear. Lane decode errors show immediately as a value in a neighbouring field, or as an unexpected counter reload.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  typedef enum logic [2:0] {
    IDX_CNT = 3'd0,
    IDX_STS = 3'd1,
    IDX_CTL = 3'd2,
    IDX_MSG = 3'd3,
    IDX_TMR = 3'd4
  } reg_idx_e;

  localparam int S1_MSG_IN  = 1;
  localparam int S1_MSG_OUT = 2;
  localparam int S1_TIMEOUT = 3;
  localparam int C1_HALT    = 11;
  localparam int C1_LOCK    = 12;

  // true when the next tick completes the programmed count
  function automatic logic at_last(input logic [15:0] cnt);
    return cnt <= 16'd1;
  endfunction

  function automatic logic [15:0] step_count(input logic [15:0] cnt,
                                             input logic [15:0] load);
    return at_last(cnt) ? load : cnt - 16'd1;
  endfunction

  // write-one-to-clear merged with set events; set wins
  function automatic logic [3:0] w1c_merge(input logic [3:0] cur,
                                           input logic [3:0] clr,
                                           input logic [3:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter import wdt_pkg::*; #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step     = tick_i & ~halt_i;
  assign expire_o = step & ~reload_i & at_last(16'(count_q));
  assign count_o  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (reload_i) count_q <= load_i;
    else if (step)     count_q <= CNT_W'(step_count(16'(count_q), 16'(load_i)));
  end
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs import wdt_pkg::*; #(
  parameter int          CNT_W    = 10,
  parameter logic [15:0] TMR_RST  = 16'h0004,
  parameter logic [15:0] CTL2_RST = 16'h0008,
  parameter logic [31:0] MSG_RST  = 32'h0300_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr_i,
  input  logic             wr_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [CNT_W-1:0] count_i,
  input  logic             expire_i,
  input  logic             no_reboot_i,
  output logic             halt_o,
  output logic             lock_o,
  output logic             reload_o,
  output logic [CNT_W-1:0] tmr_o,
  output logic             timeout_sts_o,
  output logic             second_sts_o,
  output logic             sys_action_o
);
  localparam int LANES = 4;

  logic sel_cnt, sel_sts, sel_ctl, sel_msg, sel_tmr;
  logic din_wr, dout_wr;
  logic [7:0]       din_q, dout_q;
  logic [3:0]       sts1_q, sts2_q, sts1_d, sts2_d;
  logic [3:0]       clr1, clr2, set1, set2;
  logic             halt_q, lock_q, act_q;
  logic [15:0]      ctl2_q;
  logic [CNT_W-1:0] tmr_q;
  logic [15:0]      tmr_wide, tmr_merge;
  logic [31:0]      msg_w;

  assign sel_cnt = wr_i && (addr_i == IDX_CNT);
  assign sel_sts = wr_i && (addr_i == IDX_STS);
  assign sel_ctl = wr_i && (addr_i == IDX_CTL);
  assign sel_msg = wr_i && (addr_i == IDX_MSG);
  assign sel_tmr = wr_i && (addr_i == IDX_TMR);

  assign reload_o = sel_cnt & (be_i[0] | be_i[1]);
  assign din_wr   = sel_cnt & be_i[2];
  assign dout_wr  = sel_cnt & be_i[3];

  // status: bit 0 unused in both halves
  assign clr1 = (sel_sts & be_i[0]) ? {wdata_i[3:1], 1'b0}   : 4'b0;
  assign clr2 = (sel_sts & be_i[2]) ? {1'b0, wdata_i[18:17], 1'b0} : 4'b0;
  assign set1 = {expire_i, dout_wr, din_wr, 1'b0};
  assign set2 = {2'b00, expire_i & sts1_q[S1_TIMEOUT], 1'b0};
  assign sts1_d = w1c_merge(sts1_q, clr1, set1);
  assign sts2_d = w1c_merge(sts2_q, clr2, set2);

  assign tmr_wide  = 16'(tmr_q);
  assign tmr_merge = {be_i[1] ? wdata_i[15:8] : tmr_wide[15:8],
                      be_i[0] ? wdata_i[7:0]  : tmr_wide[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts1_q <= '0;
      sts2_q <= '0;
      halt_q <= 1'b0;
      lock_q <= 1'b0;
      ctl2_q <= CTL2_RST;
      tmr_q  <= CNT_W'(TMR_RST);
      din_q  <= '0;
      dout_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sts1_q <= sts1_d;
      sts2_q <= sts2_d;
      act_q  <= expire_i & sts1_q[S1_TIMEOUT] & ~no_reboot_i;
      if (sel_ctl && be_i[1]) begin
        halt_q <= wdata_i[C1_HALT];
        lock_q <= lock_q | wdata_i[C1_LOCK];
      end
      if (sel_ctl && be_i[2]) ctl2_q[7:0]  <= wdata_i[23:16];
      if (sel_ctl && be_i[3]) ctl2_q[15:8] <= wdata_i[31:24];
      if (sel_tmr)            tmr_q        <= tmr_merge[CNT_W-1:0];
      if (din_wr)             din_q        <= wdata_i[23:16];
      if (dout_wr)            dout_q       <= wdata_i[31:24];
    end
  end

  // four plain read/write bytes, one per lane
  for (genvar g = 0; g < LANES; g++) begin : g_msg
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                  byte_q <= MSG_RST[8*g +: 8];
      else if (sel_msg && be_i[g]) byte_q <= wdata_i[8*g +: 8];
    end
    assign msg_w[8*g +: 8] = byte_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_CNT: rdata_o = {dout_q, din_q, 16'(count_i)};
      IDX_STS: rdata_o = {12'b0, sts2_q, 12'b0, sts1_q};
      IDX_CTL: rdata_o = {ctl2_q, 3'b0, lock_q, halt_q, 11'b0};
      IDX_MSG: rdata_o = msg_w;
      IDX_TMR: rdata_o = {16'b0, tmr_wide};
      default: rdata_o = '0;
    endcase
  end

  assign halt_o        = halt_q;
  assign lock_o        = lock_q;
  assign tmr_o         = tmr_q;
  assign timeout_sts_o = sts1_q[S1_TIMEOUT];
  assign second_sts_o  = sts2_q[1];
  assign sys_action_o  = act_q;
endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top #(
  parameter int          CNT_W    = 10,
  parameter logic [15:0] TMR_RST  = 16'h0004,
  parameter logic [15:0] CTL2_RST = 16'h0008,
  parameter logic [31:0] MSG_RST  = 32'h0300_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        no_reboot_i,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic [3:0]  bus_be_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        sys_action_o
);
  logic [CNT_W-1:0] count_w, tmr_w;
  logic halt_w, lock_w, reload_w, expire_w, timeout_sts_w, second_sts_w;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_w),
    .reload_i(reload_w), .load_i(tmr_w), .count_o(count_w), .expire_o(expire_w)
  );

  wdt_regs #(.CNT_W(CNT_W), .TMR_RST(TMR_RST), .CTL2_RST(CTL2_RST),
             .MSG_RST(MSG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .be_i(bus_be_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .count_i(count_w), .expire_i(expire_w), .no_reboot_i(no_reboot_i),
    .halt_o(halt_w), .lock_o(lock_w), .reload_o(reload_w), .tmr_o(tmr_w),
    .timeout_sts_o(timeout_sts_w), .second_sts_o(second_sts_w),
    .sys_action_o(sys_action_o)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             no_reboot_i,
  input logic             halt_w,
  input logic             lock_w,
  input logic             reload_w,
  input logic             expire_w,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] tmr_w,
  input logic             timeout_sts_w,
  input logic             second_sts_w,
  input logic             sys_action_o
);
  a_r2_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    reload_w |=> count_w == $past(tmr_w));

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_w && !reload_w) |=> $stable(count_w));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_w && !reload_w && count_w > 1) |=> count_w == $past(count_w) - 1'b1);

  a_r5_expiry_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (timeout_sts_w && count_w == $past(tmr_w)));

  a_r7_second_status: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && timeout_sts_w) |=> second_sts_w);

  a_r8_action_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    !(expire_w && timeout_sts_w && !no_reboot_i) |=> !sys_action_o);

  a_r8_action_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && timeout_sts_w && !no_reboot_i) |=> sys_action_o);

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |=> lock_w);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .no_reboot_i(no_reboot_i),
  .halt_w(halt_w), .lock_w(lock_w), .reload_w(reload_w), .expire_w(expire_w),
  .count_w(count_w), .tmr_w(tmr_w), .timeout_sts_w(timeout_sts_w),
  .second_sts_w(second_sts_w), .sys_action_o(sys_action_o)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        no_reboot = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_action;

  int checks = 0;
  int errors = 0;
  int act_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .no_reboot_i(no_reboot),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sys_action_o(sys_action)
  );

  always @(negedge clk) if (rst_n && sys_action) act_cnt++;

  // {timeout value written, ticks to first expiry}
  localparam logic [31:0] VEC [5] = '{
    {16'h0001, 16'd1}, {16'h0002, 16'd2}, {16'h0005, 16'd5},
    {16'h0011, 16'd17}, {16'h0403, 16'd3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_all();
    bus_wr(3'd1, 4'b0101, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] v, prev;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_rd(3'd0, v); check(v == 32'h0, "R1 idx0", v, 32'h0);
    bus_rd(3'd1, v); check(v == 32'h0, "R1 idx1", v, 32'h0);
    bus_rd(3'd2, v); check(v == 32'h0008_0000, "R1 idx2", v, 32'h0008_0000);
    bus_rd(3'd3, v); check(v == 32'h0300_0000, "R1 idx3", v, 32'h0300_0000);
    bus_rd(3'd4, v); check(v == 32'h4, "R1 idx4", v, 32'h4);

    // table walk: R2, R4, R5, R12
    foreach (VEC[k]) begin
      bus_wr(3'd4, 4'b0011, {16'h0, VEC[k][31:16]});
      clear_all();
      bus_wr(3'd0, 4'b0011, 32'h0);
      bus_rd(3'd0, v);
      check(v[9:0] == VEC[k][9:0], "R2 reload value", {22'h0, v[9:0]}, {22'h0, VEC[k][9:0]});
      n = 0;
      do begin
        bus_rd(3'd0, prev);
        do_ticks(1);
        n++;
        bus_rd(3'd1, v);
        if (!v[3]) begin
          bus_rd(3'd0, v);
          check(v[9:0] == prev[9:0] - 10'd1, "R4 decrement", {22'h0, v[9:0]},
                {22'h0, prev[9:0] - 10'd1});
          v = 32'h0;
        end
      end while (!v[3] && n < 2000);
      check(n == int'(VEC[k][15:0]), "R5/R12 ticks to expiry", n, VEC[k][15:0]);
      bus_rd(3'd0, v);
      check(v[9:0] == VEC[k][9:0], "R5 reload after expiry", {22'h0, v[9:0]},
            {22'h0, VEC[k][9:0]});
    end

    // R3 halt
    bus_wr(3'd4, 4'b0011, 32'd10);
    bus_wr(3'd2, 4'b0010, 32'h0000_0800);
    bus_wr(3'd0, 4'b0001, 32'h0);
    do_ticks(3);
    bus_rd(3'd0, v); check(v[9:0] == 10'd10, "R3 halted hold", v, 32'd10);
    bus_wr(3'd2, 4'b0010, 32'h0);
    do_ticks(1);
    bus_rd(3'd0, v); check(v[9:0] == 10'd9, "R3 resume", v, 32'd9);

    // R11 upper lanes of index 0 do not reload; R10 message bits
    clear_all();
    bus_wr(3'd0, 4'b0100, 32'h00AA_0000);
    bus_rd(3'd1, v); check(v == 32'h2, "R10 data-in sets bit1", v, 32'h2);
    bus_wr(3'd0, 4'b1000, 32'h5500_0000);
    bus_rd(3'd1, v); check(v == 32'h6, "R10 data-out sets bit2", v, 32'h6);
    bus_rd(3'd0, v); check(v == 32'h55AA_0009, "R11 no reload from upper lanes", v, 32'h55AA_0009);

    // R6 write 0 keeps, write back clears
    bus_wr(3'd1, 4'b0101, 32'h0);
    bus_rd(3'd1, v); check(v == 32'h6, "R6 write zero keeps", v, 32'h6);
    bus_wr(3'd1, 4'b0101, v);
    bus_rd(3'd1, v); check(v == 32'h0, "R6 write back clears", v, 32'h0);

    // R11 control2 lanes leave control1 alone
    bus_wr(3'd2, 4'b0010, 32'h0000_0800);
    bus_wr(3'd2, 4'b1100, 32'h1234_0000);
    bus_rd(3'd2, v); check(v == 32'h1234_0800, "R11 ctl2 lanes", v, 32'h1234_0800);
    bus_wr(3'd2, 4'b0010, 32'h0);

    // R7/R8: single timeouts cleared in between -> no escalation
    no_reboot = 1'b0;
    bus_wr(3'd4, 4'b0011, 32'd3);
    clear_all();
    bus_wr(3'd0, 4'b0011, 32'h0);
    n = act_cnt;
    do_ticks(3); clear_all(); do_ticks(3);
    bus_rd(3'd1, v); check(v == 32'h8, "R7 cleared first, no second", v, 32'h8);
    check(act_cnt == n, "R8 no action without pending status", act_cnt, n);
    // second expiry with status pending, no_reboot low
    do_ticks(3);
    bus_rd(3'd1, v); check(v == 32'h0002_0008, "R7 second status", v, 32'h0002_0008);
    check(act_cnt == n + 1, "R8 action pulse", act_cnt, n + 1);
    // same with no_reboot high
    no_reboot = 1'b1;
    clear_all();
    bus_wr(3'd0, 4'b0011, 32'h0);
    n = act_cnt;
    do_ticks(6);
    bus_rd(3'd1, v); check(v == 32'h0002_0008, "R7 second status gated run", v, 32'h0002_0008);
    check(act_cnt == n, "R8 no_reboot suppresses action", act_cnt, n);
    bus_wr(3'd1, 4'b0101, v);
    bus_rd(3'd1, v); check(v == 32'h0, "R6 both halves cleared", v, 32'h0);

    // R5/R12 maximum value
    bus_wr(3'd4, 4'b0011, 32'h0000_FFFF);
    bus_rd(3'd4, v); check(v == 32'h3FF, "R12 mask", v, 32'h3FF);
    bus_wr(3'd0, 4'b0011, 32'h0);
    do_ticks(1022);
    bus_rd(3'd0, v); check(v[9:0] == 10'd1, "R5 max count at one", v, 32'd1);
    bus_rd(3'd1, v); check(v[3] == 1'b0, "R5 max not yet expired", v, 32'h0);
    do_ticks(1);
    bus_rd(3'd1, v); check(v[3] == 1'b1, "R5 max expiry", v, 32'h8);

    // R9 lock sticky
    bus_wr(3'd2, 4'b0010, 32'h0000_1000);
    bus_wr(3'd2, 4'b0010, 32'h0);
    bus_rd(3'd2, v); check(v[12] == 1'b1, "R9 lock sticky", v, 32'h1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule